// File: doc/BRIEF.md
# Receive-Inhibit and Power-On Status Flags

This block keeps two sticky flags for a token-passing LAN node controller and presents them as an 8-bit read-only status byte. The receive-inhibit flag shows that the node will not take in another packet. It is high after any reset. A receive-enable command clears it. It sets again by itself as soon as one packet has been stored into the buffer page that the command named. While the flag is high, every packet addressed to the node is refused, and the block asks the transmitter for a NAK.

The power-on flag shows that the controller has been reset since software last acknowledged it. A hardware reset, a software reset strobe, or a write of zero to the node-ID register each set this flag. A clear-flags command clears it. An interrupt request is formed from the status byte and a mask byte supplied by the mask register, and it is registered for one cycle.

Top module: `netstat_flags`

## Requirements
- R1: While hardware reset (rst_ni low) is asserted, status_o reads 8'h90, irq_o reads 0 and nak_req_o reads 0.
- R2: A rx_enable_cmd_i pulse clears status bit 7 (receive-inhibit) on the next clock edge, unless sw_reset_i is high in the same cycle.
- R3: A pkt_stored_i pulse sets status bit 7 on the next clock edge when rx_enable_cmd_i and sw_reset_i are low. When none of the three inputs is high, bit 7 holds its value.
- R4: If pkt_stored_i and rx_enable_cmd_i are high in the same cycle, without sw_reset_i, bit 7 is 0 after the edge.
- R5: nak_req_o is high for exactly the one cycle that follows a cycle in which pkt_addressed_i was high while bit 7 was 1. It is low after every other cycle.
- R6: sw_reset_i sets both bit 7 and bit 4 on the next edge. It overrides rx_enable_cmd_i and clr_flags_cmd_i.
- R7: nid_wr_i with nid_data_i equal to 0 sets bit 4 (power-on) on the next edge. A node-ID write with any nonzero data leaves bit 4 unchanged.
- R8: clr_flags_cmd_i clears bit 4 on the next edge, unless a set condition from R6 or R7 is present in the same cycle. In that case bit 4 is 1.
- R9: Status bits 6, 5, 3, 2, 1 and 0 always read 0.
- R10: irq_o equals the OR over all bits of (status_o AND int_mask_i) as sampled at the previous clock edge.
- R11: pkt_addressed_i has no effect on status_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous hardware reset, active low |
| sw_reset_i | input | 1 | Software reset strobe |
| nid_wr_i | input | 1 | Node-ID register write strobe |
| nid_data_i | input | 8 | Data written to the node-ID register |
| rx_enable_cmd_i | input | 1 | Receive-enable command strobe |
| clr_flags_cmd_i | input | 1 | Clear-flags command strobe |
| pkt_stored_i | input | 1 | A received packet was stored in the enabled page |
| pkt_addressed_i | input | 1 | An incoming packet is addressed to this node |
| int_mask_i | input | 8 | Interrupt mask, one bit per status bit |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Registered interrupt request |
| nak_req_o | output | 1 | One-cycle NAK request to the transmitter |

## Verification
The bench applies every combination of the seven strobe inputs from each of the four flag states, with a rotating mask. It compares every output in every cycle against an arithmetic model. The corner cases it targets are simultaneous events:
- Enable and store in the same cycle. A design with the wrong priority would leave the receiver locked.
- Software reset together with either command. A design that got this wrong would let the command win and hide the reset.
- Clear-flags together with a zero node-ID write. A design that got this wrong would drop the power-on indication.
- An addressed packet in the same cycle as an enable. A design that got this wrong would refuse or accept the packet based on the updated flag rather than the current one.

The bench also writes nonzero node-ID data. A design that decoded the data wrongly would set the power-on flag on such a write.

// File: rtl/netstat_pkg.sv
package netstat_pkg;
    parameter int STAT_W  = 8;
    parameter int NID_W   = 8;
    parameter int INH_POS = 7;
    parameter int PON_POS = 4;

    typedef struct packed {
        logic inhibit;
        logic nak;
    } rx_state_t;

    typedef struct packed {
        logic pon;
    } pon_state_t;
endpackage

// File: rtl/rx_gate.sv
module rx_gate (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sw_reset_i,
    input  logic enable_i,
    input  logic stored_i,
    input  logic addressed_i,
    output logic inhibit_o,
    output logic nak_o
);
    import netstat_pkg::*;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // The refusal decision uses the flag value held before this edge.
        st_d.nak = addressed_i & st_q.inhibit;
        if (sw_reset_i)
            st_d.inhibit = 1'b1;
        else if (enable_i)
            st_d.inhibit = 1'b0;
        else if (stored_i)
            st_d.inhibit = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.inhibit <= 1'b1;
            st_q.nak     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inhibit_o = st_q.inhibit;
    assign nak_o     = st_q.nak;
endmodule

// File: rtl/pon_flag.sv
module pon_flag #(
    parameter int NID_W = netstat_pkg::NID_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sw_reset_i,
    input  logic             nid_wr_i,
    input  logic [NID_W-1:0] nid_data_i,
    input  logic             clear_i,
    output logic             pon_o
);
    import netstat_pkg::*;

    pon_state_t st_d, st_q;
    logic       set_ev;

    always_comb begin
        set_ev = sw_reset_i | (nid_wr_i & (nid_data_i == '0));
        st_d   = st_q;
        if (set_ev)
            st_d.pon = 1'b1;
        else if (clear_i)
            st_d.pon = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            st_q.pon <= 1'b1;
        else
            st_q <= st_d;
    end

    assign pon_o = st_q.pon;
endmodule

// File: rtl/irq_gen.sv
module irq_gen #(
    parameter int W = netstat_pkg::STAT_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);
    logic irq_d, irq_q;

    always_comb irq_d = |(status_i & mask_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            irq_q <= 1'b0;
        else
            irq_q <= irq_d;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/netstat_flags.sv
module netstat_flags
    import netstat_pkg::*;
#(
    parameter int SW  = STAT_W,
    parameter int NW  = NID_W,
    parameter int INH = INH_POS,
    parameter int PON = PON_POS
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          sw_reset_i,
    input  logic          nid_wr_i,
    input  logic [NW-1:0] nid_data_i,
    input  logic          rx_enable_cmd_i,
    input  logic          clr_flags_cmd_i,
    input  logic          pkt_stored_i,
    input  logic          pkt_addressed_i,
    input  logic [SW-1:0] int_mask_i,
    output logic [SW-1:0] status_o,
    output logic          irq_o,
    output logic          nak_req_o
);
    logic inhibit, pon;
    logic [SW-1:0] status;

    rx_gate u_rx (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sw_reset_i (sw_reset_i),
        .enable_i   (rx_enable_cmd_i),
        .stored_i   (pkt_stored_i),
        .addressed_i(pkt_addressed_i),
        .inhibit_o  (inhibit),
        .nak_o      (nak_req_o)
    );

    pon_flag #(.NID_W(NW)) u_pon (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sw_reset_i (sw_reset_i),
        .nid_wr_i   (nid_wr_i),
        .nid_data_i (nid_data_i),
        .clear_i    (clr_flags_cmd_i),
        .pon_o      (pon)
    );

    // Status byte: flag bits at their positions, everything else tied low.
    for (genvar b = 0; b < SW; b++) begin : g_bit
        if (b == INH) begin : g_inh
            assign status[b] = inhibit;
        end else if (b == PON) begin : g_pon
            assign status[b] = pon;
        end else begin : g_zero
            assign status[b] = 1'b0;
        end
    end

    irq_gen #(.W(SW)) u_irq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .status_i(status),
        .mask_i  (int_mask_i),
        .irq_o   (irq_o)
    );

    assign status_o = status;
endmodule

// File: rtl/netstat_flags_chk.sv
module netstat_flags_chk #(
    parameter int SW = 8,
    parameter int NW = 8,
    parameter int INH = 7,
    parameter int PON = 4
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          sw_reset_i,
    input logic          nid_wr_i,
    input logic [NW-1:0] nid_data_i,
    input logic          rx_enable_cmd_i,
    input logic          clr_flags_cmd_i,
    input logic          pkt_stored_i,
    input logic          pkt_addressed_i,
    input logic [SW-1:0] int_mask_i,
    input logic [SW-1:0] status_o,
    input logic          irq_o,
    input logic          nak_req_o
);
    localparam logic [SW-1:0] FLAG_MASK = (SW'(1) << INH) | (SW'(1) << PON);

    // R2
    enable_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_enable_cmd_i && !sw_reset_i |=> !status_o[INH]);
    // R3
    stored_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pkt_stored_i && !rx_enable_cmd_i |=> status_o[INH]);
    // R5
    nak_on_inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pkt_addressed_i && status_o[INH] |=> nak_req_o);
    // R5
    no_spurious_nak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pkt_addressed_i && status_o[INH]) |=> !nak_req_o);
    // R6
    sw_reset_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sw_reset_i |=> status_o[INH] && status_o[PON]);
    // R7
    zero_nid_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nid_wr_i && nid_data_i == '0 |=> status_o[PON]);
    // R8
    clear_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_flags_cmd_i && !sw_reset_i && !(nid_wr_i && nid_data_i == '0) |=> !status_o[PON]);
    // R9
    reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o & ~FLAG_MASK) == '0);
    // R10
    irq_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        |(status_o & int_mask_i) |=> irq_o);
    // R10
    irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|(status_o & int_mask_i)) |=> !irq_o);
endmodule

bind netstat_flags netstat_flags_chk #(.SW(SW), .NW(NW), .INH(INH), .PON(PON)) u_chk (.*);

// File: tb/netstat_flags_test.sv
module netstat_flags_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_rst = 1'b0, nid_wr = 1'b0, en = 1'b0, clr = 1'b0, stored = 1'b0, addr = 1'b0;
    logic [7:0] nid_data = 8'h00;
    logic [7:0] mask = 8'h00;
    logic [7:0] status;
    logic       irq, nak;

    int tests = 0;
    int fails = 0;
    bit m_inh, m_pon, e_irq, e_nak;

    always #2 clk = ~clk;

    netstat_flags uut (
        .clk_i(clk), .rst_ni(rst_n), .sw_reset_i(sw_rst), .nid_wr_i(nid_wr),
        .nid_data_i(nid_data), .rx_enable_cmd_i(en), .clr_flags_cmd_i(clr),
        .pkt_stored_i(stored), .pkt_addressed_i(addr), .int_mask_i(mask),
        .status_o(status), .irq_o(irq), .nak_req_o(nak)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_status();
        return {m_inh, 2'b00, m_pon, 4'b0000};
    endfunction

    // One clocked step: inputs applied now (away from the edge), model advanced, outputs checked.
    task automatic step(input bit s, input bit w, input logic [7:0] d, input bit e,
                        input bit c, input bit st, input bit a, input logic [7:0] m);
        bit n_inh, n_pon;
        sw_rst = s; nid_wr = w; nid_data = d; en = e; clr = c; stored = st; addr = a; mask = m;
        e_irq = |(model_status() & m);
        e_nak = a & m_inh;
        n_inh = s ? 1'b1 : (e ? 1'b0 : (st ? 1'b1 : m_inh));
        n_pon = (s | (w & (d == 8'h00))) ? 1'b1 : (c ? 1'b0 : m_pon);
        @(posedge clk);
        m_inh = n_inh; m_pon = n_pon;
        @(negedge clk);
        // R2 R3 R4 R6 R11: receive-inhibit bit
        check("R2 R3 R4 R6 R11 bit7", {7'd0, status[7]}, {7'd0, m_inh});
        // R6 R7 R8 R11: power-on bit
        check("R6 R7 R8 R11 bit4", {7'd0, status[4]}, {7'd0, m_pon});
        check("R9 reserved bits", status & 8'h6F, 8'h00);
        check("R10 irq", {7'd0, irq}, {7'd0, e_irq});
        check("R5 nak", {7'd0, nak}, {7'd0, e_nak});
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sw_rst = 0; nid_wr = 0; en = 0; clr = 0; stored = 0; addr = 0; mask = 8'hFF;
        #1;
        m_inh = 1'b1; m_pon = 1'b1;
        check("R1 reset status", status, 8'h90);
        check("R1 reset irq", {7'd0, irq}, 8'h00);
        check("R1 reset nak", {7'd0, nak}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        repeat (2) @(negedge clk);
        hw_reset();
        // First cycle after reset: irq reflects masked reset status (R10).
        step(0, 0, 8'h00, 0, 0, 0, 1, 8'h80);
        for (int pass = 0; pass < 4; pass++) begin
            for (int combo = 0; combo < 128; combo++) begin
                logic [7:0] mk;
                logic [7:0] dv;
                mk = 8'((combo * 37 + pass * 91) & 255);
                dv = combo[2] ? 8'h00 : 8'((combo * 13 + 1) | 1);
                // preset the flag state for this pass
                step(0, pass[1], 8'h00, !pass[0], !pass[1], pass[0], 0, mk);
                step(combo[0], combo[1], dv, combo[3], combo[4], combo[5], combo[6], mk);
            end
        end
        // R7: every nonzero node-ID value leaves a clear power-on flag alone
        step(0, 0, 8'h00, 0, 1, 0, 0, 8'h10);
        for (int v = 1; v < 256; v++) step(0, 1, 8'(v), 0, 0, 0, 0, 8'h10);
        // R4: enable and store together, repeated
        for (int k = 0; k < 4; k++) step(0, 0, 8'h00, 1, 0, 1, 1, 8'h80);
        hw_reset();
        step(0, 0, 8'h00, 0, 0, 0, 0, 8'h00);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule